// File: doc/BRIEF.md
# Link-Side Receive Stream Decoder

The block sits on the link side of a serial-bus PHY/link interface. On every clock it samples a 2-bit control bus and an 8-bit data bus, and follows the receive framing. A receive starts with a run of all-ones "data-on" cycles. The first non-all-ones receive cycle carries a speed code. Every receive cycle after that carries one packet byte, and a return to idle closes the packet. The block turns this stream into a byte strobe with start and end markers. It also reports the decoded speed and its format bit, flags null packets, and captures any bus-status byte that the PHY inserts on a status cycle.

The link states its top supported speed on a 2-bit input. A packet whose speed code is reserved, or faster than that limit, is flagged as dropped, and its bytes are never delivered. An illegal control value (11b) aborts any packet in progress and raises an error pulse. Every output is registered. Inputs sampled at clock edge k show their result just after edge k.

Top module: `rx_stream_decoder`

## Requirements
- R1: After reset, every strobe output (spd_vld_o, drop_o, byte_vld_o, sop_o, eop_o, null_o, stat_vld_o, err_o) is low.
- R2: Control codes are idle = 00b, status = 01b, receive = 10b. A receive cycle with data 0xFF is a data-on cycle and produces no output. A receive operation may begin from idle or directly after a status cycle.
- R3: A status cycle (control 01b) gives stat_vld_o high for one cycle, with stat_o equal to the data sampled. If it occurs during data-on, the prefix continues afterwards.
- R4: The first receive cycle whose data is not 0xFF is the speed code. It pulses spd_vld_o. Valid codes are 0x00/0x01 (rank 0), 0x04/0x05 (rank 1), 0x08/0x09 (rank 2) and 0x0D (rank 3). spd_o gives the rank and spd_beta_o gives data bit 0.
- R5: After an accepted speed code, each receive cycle delivers its data on byte_o with byte_vld_o. sop_o marks the first such byte, and the speed code itself is never delivered as a byte.
- R6: Idle after an accepted speed code pulses eop_o for one cycle.
- R7: Idle after only data-on (and status) cycles pulses null_o and delivers no byte.
- R8: A reserved speed code pulses drop_o with spd_ok_o low. No byte, sop or eop follows for that packet.
- R9: A valid code whose rank exceeds max_spd_i is dropped as in R8. A rank equal to max_spd_i is accepted, with spd_ok_o high.
- R10: Control 11b pulses err_o and abandons any packet in progress with no eop_o. The next receive cycle starts a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 2 | Control bus from the PHY |
| d_i | input | 8 | Data bus from the PHY |
| max_spd_i | input | 2 | Highest speed rank the link accepts (0 = S100 .. 3 = S800) |
| spd_vld_o | output | 1 | Speed code decoded this cycle |
| spd_o | output | 2 | Speed rank of the current packet |
| spd_beta_o | output | 1 | Format bit of the speed code |
| spd_ok_o | output | 1 | Speed code accepted |
| drop_o | output | 1 | Packet rejected (reserved or over-speed) |
| byte_vld_o | output | 1 | Packet byte valid |
| byte_o | output | 8 | Packet byte |
| sop_o | output | 1 | First byte of the packet |
| eop_o | output | 1 | Packet ended |
| null_o | output | 1 | Null packet ended |
| stat_vld_o | output | 1 | Status byte captured |
| stat_o | output | 8 | Captured status byte |
| err_o | output | 1 | Illegal control code seen |

## Verification
Each result is due exactly one clock after the inputs that cause it: speed, byte, status, null, end and error strobes all come out of a single register stage. The bench changes inputs on the falling edge and samples just after the following rising edge. Each driven cycle is therefore paired with its own result, and an output that arrives one cycle early or late fails the check for the cycle. Every cycle of every scenario checks the whole strobe set, not just the expected strobe, so a stray byte during a dropped packet or a missing sop is caught where it happens.

// File: rtl/rx_dec_pkg.sv
package rx_dec_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'b00,
    CTL_STAT = 2'b01,
    CTL_RECV = 2'b10,
    CTL_BAD  = 2'b11
  } ctl_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_PREFIX,
    FR_DATA,
    FR_DROP
  } fr_state_e;
endpackage

// File: rtl/rx_spd_decode.sv
module rx_spd_decode #(
  parameter int DATA_W = 8,
  parameter int SPD_W  = 2
) (
  input  logic [DATA_W-1:0] code_i,
  input  logic [SPD_W-1:0]  max_spd_i,
  output logic              known_o,
  output logic [SPD_W-1:0]  rank_o,
  output logic              beta_o,
  output logic              ok_o
);
  localparam int RANK_LSB = 2;
  localparam logic [SPD_W-1:0] TOP_RANK = '1;

  logic upper_zero;

  assign upper_zero = (code_i[DATA_W-1:RANK_LSB+SPD_W] == '0);
  assign rank_o     = code_i[RANK_LSB+SPD_W-1:RANK_LSB];
  assign beta_o     = code_i[0];
  // top rank exists only in beta format
  assign known_o    = upper_zero && !code_i[1] && ((rank_o != TOP_RANK) || code_i[0]);
  assign ok_o       = known_o && (rank_o <= max_spd_i);
endmodule

// File: rtl/rx_stat_cap.sv
module rx_stat_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      stat_o <= '0;
    end else begin
      vld_o <= hit_i;
      if (hit_i) stat_o <= d_i;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SPD_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ctl_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              code_ok_i,
  input  logic [SPD_W-1:0]  code_rank_i,
  input  logic              code_beta_i,
  output logic              spd_vld_o,
  output logic [SPD_W-1:0]  spd_o,
  output logic              spd_beta_o,
  output logic              spd_ok_o,
  output logic              drop_o,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              null_o,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] DATA_ON = '1;

  fr_state_e state_q;
  logic      first_q;
  ctl_e      ctl;

  assign ctl = ctl_e'(ctl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FR_IDLE;
      first_q    <= 1'b0;
      spd_vld_o  <= 1'b0;
      spd_o      <= '0;
      spd_beta_o <= 1'b0;
      spd_ok_o   <= 1'b0;
      drop_o     <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      sop_o      <= 1'b0;
      eop_o      <= 1'b0;
      null_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      spd_vld_o  <= 1'b0;
      drop_o     <= 1'b0;
      byte_vld_o <= 1'b0;
      sop_o      <= 1'b0;
      eop_o      <= 1'b0;
      null_o     <= 1'b0;
      err_o      <= 1'b0;
      unique case (ctl)
        CTL_BAD: begin
          err_o   <= 1'b1;
          state_q <= FR_IDLE;
        end
        CTL_STAT: begin
          // status byte handled by capture unit; framing state held
        end
        CTL_IDLE: begin
          if (state_q == FR_PREFIX) null_o <= 1'b1;
          if (state_q == FR_DATA)   eop_o  <= 1'b1;
          state_q <= FR_IDLE;
        end
        CTL_RECV: begin
          unique case (state_q)
            FR_IDLE, FR_PREFIX: begin
              if (d_i == DATA_ON) begin
                state_q <= FR_PREFIX;
              end else begin
                spd_vld_o  <= 1'b1;
                spd_o      <= code_rank_i;
                spd_beta_o <= code_beta_i;
                spd_ok_o   <= code_ok_i;
                drop_o     <= !code_ok_i;
                first_q    <= 1'b1;
                state_q    <= code_ok_i ? FR_DATA : FR_DROP;
              end
            end
            FR_DATA: begin
              byte_vld_o <= 1'b1;
              byte_o     <= d_i;
              sop_o      <= first_q;
              first_q    <= 1'b0;
            end
            FR_DROP: begin
              // payload of a rejected packet is discarded
            end
          endcase
        end
      endcase
    end
  end

  // R8
  drop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FR_DROP) |=> !byte_vld_o && !eop_o);

  // R5
  sop_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> byte_vld_o && $past(first_q));

  // R7
  null_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({null_o, eop_o, err_o, byte_vld_o}));
endmodule

// File: rtl/rx_stream_decoder.sv
module rx_stream_decoder
  import rx_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SPD_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ctl_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [SPD_W-1:0]  max_spd_i,
  output logic              spd_vld_o,
  output logic [SPD_W-1:0]  spd_o,
  output logic              spd_beta_o,
  output logic              spd_ok_o,
  output logic              drop_o,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              null_o,
  output logic              stat_vld_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              err_o
);
  logic              code_known;
  logic              code_ok;
  logic [SPD_W-1:0]  code_rank;
  logic              code_beta;

  rx_spd_decode #(.DATA_W(DATA_W), .SPD_W(SPD_W)) u_dec (
    .code_i    (d_i),
    .max_spd_i (max_spd_i),
    .known_o   (code_known),
    .rank_o    (code_rank),
    .beta_o    (code_beta),
    .ok_o      (code_ok)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .SPD_W(SPD_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl_i),
    .d_i         (d_i),
    .code_ok_i   (code_ok),
    .code_rank_i (code_rank),
    .code_beta_i (code_beta),
    .spd_vld_o   (spd_vld_o),
    .spd_o       (spd_o),
    .spd_beta_o  (spd_beta_o),
    .spd_ok_o    (spd_ok_o),
    .drop_o      (drop_o),
    .byte_vld_o  (byte_vld_o),
    .byte_o      (byte_o),
    .sop_o       (sop_o),
    .eop_o       (eop_o),
    .null_o      (null_o),
    .err_o       (err_o)
  );

  rx_stat_cap #(.DATA_W(DATA_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (ctl_i == CTL_STAT),
    .d_i    (d_i),
    .vld_o  (stat_vld_o),
    .stat_o (stat_o)
  );

  // R3
  stat_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_vld_o |-> (stat_o == $past(d_i)) && ($past(ctl_i) == CTL_STAT));

  // R5
  byte_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> (byte_o == $past(d_i)) && ($past(ctl_i) == CTL_RECV));

  // R4
  spd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spd_vld_o |-> ($past(d_i) != '1) && ($past(ctl_i) == CTL_RECV));

  // R6
  eop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> $past(ctl_i) == CTL_IDLE);

  // R7
  null_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    null_o |-> $past(ctl_i) == CTL_IDLE);

  // R9
  spd_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spd_vld_o && spd_ok_o) |-> spd_o <= $past(max_spd_i));

  // R8
  drop_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spd_vld_o && !$past(code_known)) |-> drop_o);

  // R10
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(ctl_i) == CTL_BAD);
endmodule

// File: tb/sim_rx_stream_decoder.sv
module sim_rx_stream_decoder;
  localparam logic [1:0] C_IDLE = 2'b00, C_STAT = 2'b01, C_RECV = 2'b10, C_BAD = 2'b11;
  localparam int K_NONE = 0, K_BYTE = 1, K_SOP = 2, K_EOP = 3, K_NULL = 4,
                 K_STAT = 5, K_SPD = 6, K_DROP = 7, K_ERR = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ctl = C_IDLE;
  logic [7:0] d = 8'h00;
  logic [1:0] max_spd = 2'd3;
  logic       spd_vld, spd_beta, spd_ok, drop, byte_vld, sop, eop, nul, stat_vld, err;
  logic [1:0] spd;
  logic [7:0] byte_q, stat;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_stream_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_i(ctl), .d_i(d), .max_spd_i(max_spd),
    .spd_vld_o(spd_vld), .spd_o(spd), .spd_beta_o(spd_beta), .spd_ok_o(spd_ok),
    .drop_o(drop), .byte_vld_o(byte_vld), .byte_o(byte_q), .sop_o(sop),
    .eop_o(eop), .null_o(nul), .stat_vld_o(stat_vld), .stat_o(stat), .err_o(err)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
    end
  endtask

  // strobes: {spd_vld, drop, byte_vld, sop, eop, null, stat_vld, err}
  // val for K_SPD: {beta, rank}; K_BYTE/K_SOP/K_STAT: data value
  task automatic step(input logic [1:0] c, input logic [7:0] v, input string req,
                      input int kind, input logic [7:0] val);
    logic [7:0] exp;
    @(negedge clk);
    ctl = c;
    d   = v;
    @(posedge clk);
    #1;
    case (kind)
      K_BYTE:  exp = 8'b0010_0000;
      K_SOP:   exp = 8'b0011_0000;
      K_EOP:   exp = 8'b0000_1000;
      K_NULL:  exp = 8'b0000_0100;
      K_STAT:  exp = 8'b0000_0010;
      K_SPD:   exp = 8'b1000_0000;
      K_DROP:  exp = 8'b1100_0000;
      K_ERR:   exp = 8'b0000_0001;
      default: exp = 8'b0000_0000;
    endcase
    chk(req, {8'h0, spd_vld, drop, byte_vld, sop, eop, nul, stat_vld, err}, {8'h0, exp});
    if (kind == K_BYTE || kind == K_SOP) chk(req, {8'h0, byte_q}, {8'h0, val});
    if (kind == K_STAT) chk(req, {8'h0, stat}, {8'h0, val});
    if (kind == K_SPD)  chk(req, {12'h0, spd_ok, spd_beta, spd}, {12'h0, 1'b1, val[2:0]});
    if (kind == K_DROP) chk(req, {15'h0, spd_ok}, 16'h0);
  endtask

  task automatic t_normal();
    max_spd = 2'd3;
    step(C_RECV, 8'hFF, "R2", K_NONE, 8'h0);
    step(C_RECV, 8'hFF, "R2", K_NONE, 8'h0);
    step(C_RECV, 8'h08, "R4", K_SPD, 8'h02);
    step(C_RECV, 8'hA1, "R5", K_SOP, 8'hA1);
    step(C_RECV, 8'hB2, "R5", K_BYTE, 8'hB2);
    step(C_RECV, 8'hFF, "R5", K_BYTE, 8'hFF);
    step(C_IDLE, 8'h00, "R6", K_EOP, 8'h0);
    step(C_IDLE, 8'h00, "R6", K_NONE, 8'h0);
    // speed code on the very first receive cycle
    step(C_RECV, 8'h04, "R4", K_SPD, 8'h01);
    step(C_RECV, 8'h3C, "R5", K_SOP, 8'h3C);
    step(C_IDLE, 8'h00, "R6", K_EOP, 8'h0);
  endtask

  task automatic t_status_prefix();
    max_spd = 2'd3;
    step(C_RECV, 8'hFF, "R2", K_NONE, 8'h0);
    step(C_STAT, 8'h5A, "R3", K_STAT, 8'h5A);
    step(C_RECV, 8'hFF, "R3", K_NONE, 8'h0);
    step(C_RECV, 8'h0D, "R4", K_SPD, 8'h07);
    step(C_RECV, 8'h11, "R5", K_SOP, 8'h11);
    step(C_IDLE, 8'h00, "R6", K_EOP, 8'h0);
  endtask

  task automatic t_null();
    step(C_RECV, 8'hFF, "R7", K_NONE, 8'h0);
    step(C_RECV, 8'hFF, "R7", K_NONE, 8'h0);
    step(C_IDLE, 8'h00, "R7", K_NULL, 8'h0);
    step(C_IDLE, 8'h00, "R7", K_NONE, 8'h0);
  endtask

  task automatic t_reserved();
    max_spd = 2'd3;
    step(C_RECV, 8'hFF, "R8", K_NONE, 8'h0);
    step(C_RECV, 8'h0C, "R8", K_DROP, 8'h0);
    step(C_RECV, 8'h33, "R8", K_NONE, 8'h0);
    step(C_RECV, 8'h44, "R8", K_NONE, 8'h0);
    step(C_IDLE, 8'h00, "R8", K_NONE, 8'h0);
    step(C_RECV, 8'h02, "R8", K_DROP, 8'h0);
    step(C_IDLE, 8'h00, "R8", K_NONE, 8'h0);
  endtask

  task automatic t_overspeed();
    max_spd = 2'd1;
    step(C_RECV, 8'hFF, "R9", K_NONE, 8'h0);
    step(C_RECV, 8'h09, "R9", K_DROP, 8'h0);
    step(C_RECV, 8'h55, "R9", K_NONE, 8'h0);
    step(C_IDLE, 8'h00, "R9", K_NONE, 8'h0);
    step(C_RECV, 8'hFF, "R9", K_NONE, 8'h0);
    step(C_RECV, 8'h05, "R9", K_SPD, 8'h05);
    step(C_RECV, 8'h66, "R9", K_SOP, 8'h66);
    step(C_IDLE, 8'h00, "R9", K_EOP, 8'h0);
    max_spd = 2'd3;
  endtask

  task automatic t_stat_to_rx();
    step(C_STAT, 8'hC3, "R3", K_STAT, 8'hC3);
    step(C_RECV, 8'hFF, "R2", K_NONE, 8'h0);
    step(C_RECV, 8'h01, "R4", K_SPD, 8'h04);
    step(C_RECV, 8'h77, "R5", K_SOP, 8'h77);
    step(C_IDLE, 8'h00, "R6", K_EOP, 8'h0);
  endtask

  task automatic t_abort();
    step(C_RECV, 8'hFF, "R10", K_NONE, 8'h0);
    step(C_RECV, 8'h00, "R10", K_SPD, 8'h00);
    step(C_RECV, 8'h12, "R10", K_SOP, 8'h12);
    step(C_BAD,  8'h34, "R10", K_ERR, 8'h0);
    step(C_IDLE, 8'h00, "R10", K_NONE, 8'h0);
    step(C_RECV, 8'hFF, "R10", K_NONE, 8'h0);
    step(C_RECV, 8'h08, "R10", K_SPD, 8'h02);
    step(C_RECV, 8'h9E, "R10", K_SOP, 8'h9E);
    step(C_IDLE, 8'h00, "R10", K_EOP, 8'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1", {8'h0, spd_vld, drop, byte_vld, sop, eop, nul, stat_vld, err}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step(C_IDLE, 8'h00, "R1", K_NONE, 8'h0);
    t_normal();
    t_status_prefix();
    t_null();
    t_reserved();
    t_overspeed();
    t_stat_to_rx();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule